// File: doc/BRIEF.md
# Command-indexed cartridge bank mapper

This block is the address-banking controller of an 8-bit console cartridge. It watches the CPU bus and the video bus. It turns each CPU address into a banked program-ROM or work-RAM address, and each video address into a banked character-memory address. It also holds the nametable mirroring mode.

Software programs the mapper in two steps. A write into the lower command window selects a command number. A write into the parameter window then loads that command's register. These registers cover:

- eight 1 KB character banks;
- three switchable 8 KB program banks;
- a banked 8 KB window at 0x6000–0x7FFF that shows ROM, disabled RAM or enabled RAM;
- the mirroring mode.

The topmost 8 KB of CPU space is fixed to the last program bank.

All address outputs are combinational from the current bus address and the registered bank state. Register writes take effect after the clock edge that samples the write strobe. Bank counts are parameters, and every bank value is reduced modulo the bank count present.

Top module: `bank_mapper`

## Requirements
- R1: A CPU write with `cpu_addr` in 0x8000–0x9FFF stores `cpu_wdata[3:0]` as the current command; the upper data bits are ignored.
- R2: A write in 0xA000–0xBFFF under commands 0–7 sets the character bank of video page N (page = `ppu_addr[12:10]`). For `ppu_addr` ≤ 0x1FFF, `chr_cs`=1 and `chr_addr` = bank·1024 + `ppu_addr[9:0]`. Above 0x1FFF, `chr_cs`=0 and `chr_addr`=0.
- R3: Commands 9, 0xA and 0xB load `cpu_wdata[5:0]` as the 8 KB program bank for 0x8000, 0xA000 and 0xC000. `prg_rom_addr` = bank·8192 + `cpu_addr[12:0]`.
- R4: Accesses in 0xE000–0xFFFF always use program bank PRG_BANKS−1.
- R5: Command 8 loads the low window: bank = data[5:0], RAM mode = data[6], RAM enable = data[7].
  - ROM mode: the window drives `prg_rom_cs` with that bank.
  - RAM mode: `wram_sel`=1 and `wram_addr` = (bank mod RAM_PAGES)·8192 + `cpu_addr[12:0]`.
  - `wram_en` is 1 only when RAM is enabled. `wram_en`=0 with `wram_sel`=1 means the read data is forced to 0.
  - `wram_we` = `cpu_we` & `wram_en`.
- R6: Command 0xC sets `mirror_mode` = data[1:0]: 0 vertical, 1 horizontal, 2 single-screen low, 3 single-screen high.
- R7: After reset the program banks are 0, 1 and 0xFE (kept as 6 bits, 0x3E), all character banks are 0, the low window is ROM bank 0 with RAM disabled, and mirroring is 0.
- R8: Every bank value is reduced modulo the number of banks present (PRG_BANKS, CHR_BANKS), so oversized values wrap.
- R9: Writes outside 0x8000–0xBFFF (including 0x6000–0x7FFF) change no register. Commands 0xD–0xF change no register.
- R10: A register write becomes visible on the outputs only after the clock edge that samples `cpu_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 14 | Video bus address |
| prg_rom_cs | output | 1 | Program ROM selected |
| prg_rom_addr | output | PRG_AW | Program ROM byte address (0 when not selected) |
| wram_sel | output | 1 | Low window is in RAM mode and addressed |
| wram_en | output | 1 | RAM access permitted |
| wram_we | output | 1 | RAM write strobe |
| wram_addr | output | RAM_AW | Work RAM byte address (0 when not selected) |
| chr_cs | output | 1 | Character memory selected |
| chr_addr | output | CHR_AW | Character memory byte address (0 when not selected) |
| mirror_mode | output | 2 | Nametable mirroring mode |

## Verification
The bench builds the mapper with PRG_BANKS=20, CHR_BANKS=48 and RAM_PAGES=4. Neither bank count is a power of two, so the 6-bit program and 8-bit character bank fields regularly exceed the bank count. This makes the modulo wrap, and the reset value 0x3E mapping to bank 2, directly observable. It also puts the fixed top bank (19) away from any all-ones pattern, so a decode that truncates instead of wrapping shows up at once.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  localparam logic [3:0] CMD_LOWWIN = 4'h8;
  localparam logic [3:0] CMD_PRG0   = 4'h9;
  localparam logic [3:0] CMD_PRG1   = 4'hA;
  localparam logic [3:0] CMD_PRG2   = 4'hB;
  localparam logic [3:0] CMD_MIRROR = 4'hC;

  localparam logic [5:0] PRG2_RESET = 6'h3E;

  typedef struct packed {
    logic [5:0] bank;
    logic       is_ram;
    logic       ram_on;
  } lowwin_t;

endpackage

// File: rtl/bank_cmd_regs.sv
module bank_cmd_regs
  import bank_mapper_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [15:0]     wr_addr,
  input  logic [7:0]      wr_data,
  output logic [7:0][7:0] chr_q,
  output logic [2:0][5:0] prg_q,
  output lowwin_t         low_q,
  output mirror_e         mir_q
);

  logic [3:0]      cmd_q, cmd_d;
  logic [7:0][7:0] chr_d;
  logic [2:0][5:0] prg_d;
  lowwin_t         low_d;
  mirror_e         mir_d;
  logic            wr_cmd, wr_par, upd_en;

  assign wr_cmd = wr_en && (wr_addr[15:13] == 3'b100);
  assign wr_par = wr_en && (wr_addr[15:13] == 3'b101);
  assign upd_en = wr_cmd || wr_par;

  always_comb begin
    cmd_d = cmd_q;
    chr_d = chr_q;
    prg_d = prg_q;
    low_d = low_q;
    mir_d = mir_q;
    if (wr_cmd) cmd_d = wr_data[3:0];
    if (wr_par) begin
      if (!cmd_q[3]) begin
        chr_d[cmd_q[2:0]] = wr_data;
      end else begin
        case (cmd_q)
          CMD_LOWWIN: begin
            low_d.bank   = wr_data[5:0];
            low_d.is_ram = wr_data[6];
            low_d.ram_on = wr_data[7];
          end
          CMD_PRG0:   prg_d[0] = wr_data[5:0];
          CMD_PRG1:   prg_d[1] = wr_data[5:0];
          CMD_PRG2:   prg_d[2] = wr_data[5:0];
          CMD_MIRROR: mir_d = mirror_e'(wr_data[1:0]);
          default:    ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      chr_q <= '0;
      prg_q <= {PRG2_RESET, 6'd1, 6'd0};
      low_q <= '0;
      mir_q <= MIR_VERT;
    end else if (upd_en) begin
      cmd_q <= cmd_d;
      chr_q <= chr_d;
      prg_q <= prg_d;
      low_q <= low_d;
      mir_q <= mir_d;
    end
  end

  AST_CMD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> (cmd_q == $past(wr_data[3:0]))); // R1

  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_cmd && !wr_par) |=> ($stable(cmd_q) && $stable(chr_q) &&
      $stable(prg_q) && $stable(low_q) && $stable(mir_q))); // R9

  AST_MIRROR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_par && cmd_q == CMD_MIRROR) |=> $stable(mir_q)); // R6

  AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(chr_q) && $stable(prg_q) && $stable(low_q))); // R10

endmodule

// File: rtl/bank_prg_decode.sv
module bank_prg_decode
  import bank_mapper_pkg::*;
#(
  parameter  int PRG_BANKS = 64,
  parameter  int RAM_PAGES = 4,
  localparam int PRG_BW    = $clog2(PRG_BANKS),
  localparam int PRG_AW    = 13 + PRG_BW,
  localparam int RAM_PW    = $clog2(RAM_PAGES),
  localparam int RAM_AW    = 13 + RAM_PW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic              cpu_we,
  input  logic [2:0][5:0]   prg_q,
  input  lowwin_t           low_q,
  output logic              rom_cs,
  output logic [PRG_AW-1:0] rom_addr,
  output logic              ram_sel,
  output logic              ram_en,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr
);

  localparam logic [PRG_BW-1:0] LAST_BANK = PRG_BW'(PRG_BANKS - 1);

  logic              win_hit;
  logic [5:0]        raw_bank;
  logic [PRG_BW-1:0] rom_bank;
  logic [RAM_PW-1:0] ram_page;

  assign win_hit = (cpu_addr[15:13] == 3'b011);

  always_comb begin
    raw_bank = low_q.bank;
    case (cpu_addr[15:13])
      3'b100:  raw_bank = prg_q[0];
      3'b101:  raw_bank = prg_q[1];
      3'b110:  raw_bank = prg_q[2];
      default: raw_bank = low_q.bank;
    endcase
  end

  always_comb begin
    if (cpu_addr[15:13] == 3'b111) rom_bank = LAST_BANK;
    else rom_bank = PRG_BW'(32'(raw_bank) % PRG_BANKS);
  end

  assign ram_page = RAM_PW'(32'(low_q.bank) % RAM_PAGES);
  assign rom_cs   = cpu_addr[15] || (win_hit && !low_q.is_ram);
  assign ram_sel  = win_hit && low_q.is_ram;
  assign ram_en   = ram_sel && low_q.ram_on;
  assign ram_we   = ram_en && cpu_we;
  assign rom_addr = rom_cs  ? {rom_bank, cpu_addr[12:0]} : '0;
  assign ram_addr = ram_sel ? {ram_page, cpu_addr[12:0]} : '0;

  AST_TOP_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b111) |-> (rom_addr[PRG_AW-1:13] == LAST_BANK)); // R4

  AST_ROM_RAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_cs, ram_sel})); // R5

  AST_RAM_WE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_sel && low_q.ram_on && cpu_we)); // R5

  AST_PRG_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> (32'(rom_addr[PRG_AW-1:13]) < PRG_BANKS)); // R8

endmodule

// File: rtl/bank_chr_decode.sv
module bank_chr_decode #(
  parameter  int CHR_BANKS = 256,
  localparam int CHR_BW    = $clog2(CHR_BANKS),
  localparam int CHR_AW    = 10 + CHR_BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [13:0]       ppu_addr,
  input  logic [7:0][7:0]   chr_q,
  output logic              chr_cs,
  output logic [CHR_AW-1:0] chr_addr
);

  logic [7:0]        page_bank;
  logic [CHR_BW-1:0] chr_bank;

  assign page_bank = chr_q[ppu_addr[12:10]];
  assign chr_bank  = CHR_BW'(32'(page_bank) % CHR_BANKS);
  assign chr_cs    = !ppu_addr[13];
  assign chr_addr  = chr_cs ? {chr_bank, ppu_addr[9:0]} : '0;

  AST_CHR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    chr_cs |-> (32'(chr_addr[CHR_AW-1:10]) < CHR_BANKS)); // R8

  AST_CHR_ABOVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ppu_addr[13] |-> (!chr_cs && chr_addr == '0)); // R2

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter  int PRG_BANKS = 64,
  parameter  int CHR_BANKS = 256,
  parameter  int RAM_PAGES = 4,
  localparam int PRG_AW    = 13 + $clog2(PRG_BANKS),
  localparam int CHR_AW    = 10 + $clog2(CHR_BANKS),
  localparam int RAM_AW    = 13 + $clog2(RAM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_we,
  input  logic [13:0]       ppu_addr,
  output logic              prg_rom_cs,
  output logic [PRG_AW-1:0] prg_rom_addr,
  output logic              wram_sel,
  output logic              wram_en,
  output logic              wram_we,
  output logic [RAM_AW-1:0] wram_addr,
  output logic              chr_cs,
  output logic [CHR_AW-1:0] chr_addr,
  output logic [1:0]        mirror_mode
);

  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic [7:0][7:0] chr_q;
  logic [2:0][5:0] prg_q;
  lowwin_t         low_q;
  mirror_e         mir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  bank_cmd_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (cpu_we),
    .wr_addr (cpu_addr),
    .wr_data (cpu_wdata),
    .chr_q   (chr_q),
    .prg_q   (prg_q),
    .low_q   (low_q),
    .mir_q   (mir_q)
  );

  bank_prg_decode #(
    .PRG_BANKS (PRG_BANKS),
    .RAM_PAGES (RAM_PAGES)
  ) u_prg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cpu_addr (cpu_addr),
    .cpu_we   (cpu_we),
    .prg_q    (prg_q),
    .low_q    (low_q),
    .rom_cs   (prg_rom_cs),
    .rom_addr (prg_rom_addr),
    .ram_sel  (wram_sel),
    .ram_en   (wram_en),
    .ram_we   (wram_we),
    .ram_addr (wram_addr)
  );

  bank_chr_decode #(
    .CHR_BANKS (CHR_BANKS)
  ) u_chr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ppu_addr (ppu_addr),
    .chr_q    (chr_q),
    .chr_cs   (chr_cs),
    .chr_addr (chr_addr)
  );

  assign mirror_mode = mir_q;

  AST_RESET_MIRROR: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (mirror_mode == 2'd0)); // R7

endmodule

// File: tb/bank_mapper_test.sv
module bank_mapper_test;

  localparam int CLK_PERIOD = 10;
  localparam int PRG_BANKS  = 20;
  localparam int CHR_BANKS  = 48;
  localparam int RAM_PAGES  = 4;
  localparam int PRG_AW     = 13 + $clog2(PRG_BANKS);
  localparam int CHR_AW     = 10 + $clog2(CHR_BANKS);
  localparam int RAM_AW     = 13 + $clog2(RAM_PAGES);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [15:0]       cpu_addr;
  logic [7:0]        cpu_wdata;
  logic              cpu_we;
  logic [13:0]       ppu_addr;
  logic              prg_rom_cs;
  logic [PRG_AW-1:0] prg_rom_addr;
  logic              wram_sel, wram_en, wram_we;
  logic [RAM_AW-1:0] wram_addr;
  logic              chr_cs;
  logic [CHR_AW-1:0] chr_addr;
  logic [1:0]        mirror_mode;

  int checks = 0;
  int fails  = 0;

  int m_cmd;
  int m_chr[8];
  int m_prg[3];
  int m_lbank, m_lram, m_lon, m_mir;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_mapper #(
    .PRG_BANKS (PRG_BANKS),
    .CHR_BANKS (CHR_BANKS),
    .RAM_PAGES (RAM_PAGES)
  ) uut (
    .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .cpu_wdata (cpu_wdata),
    .cpu_we (cpu_we), .ppu_addr (ppu_addr), .prg_rom_cs (prg_rom_cs),
    .prg_rom_addr (prg_rom_addr), .wram_sel (wram_sel), .wram_en (wram_en),
    .wram_we (wram_we), .wram_addr (wram_addr), .chr_cs (chr_cs),
    .chr_addr (chr_addr), .mirror_mode (mirror_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  function automatic int exp_rom_cs(input int a);
    return ((a >= 'h8000) || (a >= 'h6000 && a < 'h8000 && m_lram == 0)) ? 1 : 0;
  endfunction

  function automatic int exp_rom_addr(input int a);
    int b;
    if (exp_rom_cs(a) == 0) return 0;
    if (a >= 'hE000)      b = PRG_BANKS - 1;
    else if (a >= 'hC000) b = m_prg[2] % PRG_BANKS;
    else if (a >= 'hA000) b = m_prg[1] % PRG_BANKS;
    else if (a >= 'h8000) b = m_prg[0] % PRG_BANKS;
    else                  b = m_lbank % PRG_BANKS;
    return b * 8192 + (a % 8192);
  endfunction

  function automatic int exp_ram_sel(input int a);
    return (a >= 'h6000 && a < 'h8000 && m_lram != 0) ? 1 : 0;
  endfunction

  function automatic int exp_chr(input int p);
    if (p >= 'h2000) return 0;
    return (m_chr[p / 1024] % CHR_BANKS) * 1024 + (p % 1024);
  endfunction

  task automatic probe(input int a, input int p);
    @(negedge clk);
    cpu_addr = 16'(a);
    ppu_addr = 14'(p);
    #1;
    chk("R3/R4/R5 rom_cs", int'(prg_rom_cs), exp_rom_cs(a));
    chk("R3/R4/R8 rom_addr", int'(prg_rom_addr), exp_rom_addr(a));
    chk("R5 wram_sel", int'(wram_sel), exp_ram_sel(a));
    chk("R5 wram_en", int'(wram_en), exp_ram_sel(a) & m_lon);
    chk("R5 wram_addr", int'(wram_addr),
        exp_ram_sel(a) != 0 ? (m_lbank % RAM_PAGES) * 8192 + (a % 8192) : 0);
    chk("R2 chr_cs", int'(chr_cs), p < 'h2000 ? 1 : 0);
    chk("R2/R8 chr_addr", int'(chr_addr), exp_chr(p));
    chk("R6 mirror", int'(mirror_mode), m_mir);
  endtask

  task automatic do_write(input int a, input int d);
    @(negedge clk);
    cpu_addr  = 16'(a);
    cpu_wdata = 8'(d);
    cpu_we    = 1'b1;
    #1;
    chk("R5 wram_we", int'(wram_we), exp_ram_sel(a) & m_lon);
    chk("R10 mirror before edge", int'(mirror_mode), m_mir);
    @(negedge clk);
    cpu_we = 1'b0;
    if (a >= 'h8000 && a < 'hA000) m_cmd = d % 16;
    else if (a >= 'hA000 && a < 'hC000) begin
      if (m_cmd < 8) m_chr[m_cmd] = d;
      else case (m_cmd)
        8:  begin m_lbank = d % 64; m_lram = (d / 64) % 2; m_lon = d / 128; end
        9:  m_prg[0] = d % 64;
        10: m_prg[1] = d % 64;
        11: m_prg[2] = d % 64;
        12: m_mir = d % 4;
        default: ;
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cpu_addr = '0; cpu_wdata = '0; cpu_we = 1'b0; ppu_addr = '0;
    m_cmd = 0; m_lbank = 0; m_lram = 0; m_lon = 0; m_mir = 0;
    m_prg[0] = 0; m_prg[1] = 1; m_prg[2] = 'h3E;
    for (int i = 0; i < 8; i++) m_chr[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R7: reset state over every region
    probe('h6123, 'h0000);
    probe('h8001, 'h1FFF);
    probe('hA002, 'h0400);
    probe('hC003, 'h2000);
    probe('hFFFF, 'h3FFF);

    // R1: upper data bits of a command write are ignored (0xF9 -> command 9)
    do_write('h9ABC, 'hF9);
    do_write('hA000, 'hFF);    // R3/R8: 0x3F -> bank 63 mod 20 = 3
    probe('h8010, 0);
    // R2/R8: character bank 200 wraps mod 48
    do_write('h8000, 'h05);
    do_write('hB000, 200);
    probe('hE000, 'h1555);
    // R5: RAM mode disabled, then enabled, page 6 mod 4 = 2
    do_write('h8000, 'h08);
    do_write('hA000, 'h46);
    probe('h7001, 0);
    do_write('h6001, 'h55);
    do_write('hA000, 'hC6);
    probe('h7001, 0);
    do_write('h7FFF, 'hAA);
    // R9: writes outside windows and unused commands change nothing
    do_write('hC000, 'h0C);
    do_write('h6000, 'h03);
    do_write('h8000, 'h0D);
    do_write('hA000, 'hFF);
    probe('h7002, 'h1400);
    // R6: every mirroring mode
    do_write('h8000, 'h0C);
    for (int k = 0; k < 4; k++) begin
      do_write('hA000, k + 4);
      probe('hE001, 0);
    end

    for (int it = 0; it < 2500; it++) begin
      int sel, a, d;
      sel = $urandom % 8;
      d   = $urandom % 256;
      if (sel < 3)       a = 'h8000 + $urandom % 'h2000;
      else if (sel < 6)  a = 'hA000 + $urandom % 'h2000;
      else               a = $urandom % 'h10000;
      do_write(a, d);
      probe('h6000 + $urandom % 'hA000, $urandom % 'h4000);
    end
    finish_run();
  end

endmodule